// File: doc/BRIEF.md
# Directory Coherence Home Controller

This block is the home-side directory engine of an invalidation-based cache coherence protocol for a machine built from eight nodes of four processors each. Every memory line homed here has one directory entry: an owner field and a coarse sharer vector with one bit per node. Requests arrive at most one per cycle. Each request is looked up, the entry is rewritten, and one or two registered messages go out. The reply channel carries data or an ownership grant to the requester. The ordered channel carries a forward to a remote owner or a single multicast invalidate to a set of nodes.

The controller is a two-stage pipeline. It never stalls, never rejects a request, never answers with a retry and never holds a line busy. A line held dirty by a remote processor is served by forwarding the request to that owner. A read to such a line leaves the owner in place and records the reader's node (dirty sharing). Invalidates collect no acknowledgements. Back-to-back requests to the same line observe each other's updates through a bypass around the directory array.

Top module: `dirc_home`

## Requirements
- R1: After reset every line is owned by memory (owner code 0x3F) with an empty sharer vector, and both output valids are low. A reset during operation restores this state for all lines.
- R2: A request sampled at clock edge N has its outputs visible after edge N+1. Requests are handled one per cycle in arrival order, and a request to the line updated by the request just before it sees that update.
- R3: Read (type 0) to a memory-owned line gives a data reply (reply kind 0) to the requester and sets the requester's node bit in the vector.
- R4: Read to a line with a processor owner sends a forward-read (ordered kind 0) to that owner, carrying the requester id, with no reply. The owner is kept and the reader's node bit is set.
- R5: Read-exclusive (type 1) makes the requester the owner and clears the vector. For a memory-owned line it gives a data reply and, when other nodes are marked, an invalidate (ordered kind 2) to them in the same cycle. For a processor-owned line it sends a forward-exclusive (ordered kind 1) to the owner whose mask lists the marked nodes.
- R6: Exclusive upgrade (type 2) behaves like R5, except that on a memory-owned line it gives a grant (reply kind 1) when the requester's node bit is set and a data reply when it is not.
- R7: Exclusive-without-data (type 3) always gives a grant and makes the requester the owner with an empty vector. It invalidates the marked nodes plus the node of any processor owner, reporting that previous owner in the ordered message.
- R8: A writeback (type 4) from the current owner returns the line to memory, keeps the vector and sends nothing. A writeback from any other id changes nothing and sends nothing.
- R9: A processor id maps to node id[4:2]. Mask bit k stands for node k, and an invalidate mask never includes the requester's own node and is never empty.
- R10: Request types 5 to 7 produce no output and leave the directory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_type | input | 3 | Request type code |
| req_addr | input | 6 | Line index |
| req_id | input | 6 | Requesting processor id |
| rep_valid | output | 1 | Reply message valid |
| rep_kind | output | 1 | 0 data, 1 grant |
| rep_dest | output | 6 | Processor receiving the reply |
| rep_addr | output | 6 | Line of the reply |
| ord_valid | output | 1 | Ordered-channel message valid |
| ord_kind | output | 2 | 0 forward-read, 1 forward-exclusive, 2 invalidate |
| ord_owner | output | 6 | Owner targeted by a forward, or previous owner |
| ord_req | output | 6 | Requester on whose behalf it is sent |
| ord_mask | output | 8 | Nodes to invalidate |
| ord_addr | output | 6 | Line of the message |

## Verification
The reply and the multicast invalidate can appear in the same cycle. This happens when an exclusive request reaches a memory-owned line that other nodes share. The bench provokes it both from the vector table and with back-to-back requests to one line, where the second request's mask exists only if the bypass carried the first request's sharer bit. In each such cycle both channels are judged together: reply kind and destination on one, and invalidate mask and previous owner on the other.

// File: rtl/dirc_pkg.sv
package dirc_pkg;

  typedef enum logic [2:0] {
    RQ_READ  = 3'd0,
    RQ_RDEX  = 3'd1,
    RQ_EXCL  = 3'd2,
    RQ_EXND  = 3'd3,
    RQ_WBACK = 3'd4
  } req_t;

  typedef enum logic {
    RP_DATA  = 1'b0,
    RP_GRANT = 1'b1
  } rep_t;

  typedef enum logic [1:0] {
    OD_FWD_RD   = 2'd0,
    OD_FWD_RDEX = 2'd1,
    OD_INVAL    = 2'd2
  } ord_t;

endpackage

// File: rtl/dirc_dir_ram.sv
module dirc_dir_ram #(
  parameter int ENTRY_W = 14,
  parameter int LINE_W  = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [LINE_W-1:0]  waddr,
  input  logic [ENTRY_W-1:0] wdata,
  input  logic               re,
  input  logic [LINE_W-1:0]  raddr,
  output logic [ENTRY_W-1:0] rdata
);
  localparam int DEPTH = 1 << LINE_W;

  logic [ENTRY_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  AST_WADDR_KNOWN: assert property (@(posedge clk) disable iff (rst)
    we |-> !$isunknown(waddr)); // R2

endmodule

// File: rtl/dirc_policy.sv
module dirc_policy
  import dirc_pkg::*;
#(
  parameter int NODES = 8,
  parameter int PROCS_PER_NODE = 4,
  parameter int ID_W = 6
) (
  input  logic             valid,
  input  logic [2:0]       rtype,
  input  logic [ID_W-1:0]  rid,
  input  logic [ID_W-1:0]  cur_own,
  input  logic [NODES-1:0] cur_vec,
  output logic             wr,
  output logic [ID_W-1:0]  nxt_own,
  output logic [NODES-1:0] nxt_vec,
  output logic             rep_v,
  output logic             rep_k,
  output logic             ord_v,
  output logic [1:0]       ord_k,
  output logic [ID_W-1:0]  ord_own,
  output logic [NODES-1:0] ord_msk
);
  localparam int NODE_W = $clog2(NODES);
  localparam int PSH    = $clog2(PROCS_PER_NODE);
  localparam logic [ID_W-1:0] MEM_OWNER = '1;

  logic             mem_own;
  logic [NODES-1:0] req_bit;
  logic [NODES-1:0] own_bit;
  logic [NODES-1:0] others;
  logic [NODES-1:0] exnd_msk;

  always_comb begin
    mem_own  = (cur_own == MEM_OWNER);
    req_bit  = NODES'(1) << rid[PSH +: NODE_W];
    own_bit  = mem_own ? '0 : (NODES'(1) << cur_own[PSH +: NODE_W]);
    others   = cur_vec & ~req_bit;
    exnd_msk = (cur_vec | own_bit) & ~req_bit;
  end

  always_comb begin
    wr      = 1'b0;
    nxt_own = cur_own;
    nxt_vec = cur_vec;
    rep_v   = 1'b0;
    rep_k   = RP_DATA;
    ord_v   = 1'b0;
    ord_k   = OD_INVAL;
    ord_own = cur_own;
    ord_msk = '0;
    if (valid) begin
      case (rtype)
        RQ_READ: begin
          wr      = 1'b1;
          nxt_vec = cur_vec | req_bit;
          if (mem_own) begin
            rep_v = 1'b1;
          end else begin
            ord_v = 1'b1;
            ord_k = OD_FWD_RD;
          end
        end
        RQ_RDEX, RQ_EXCL: begin
          wr      = 1'b1;
          nxt_own = rid;
          nxt_vec = '0;
          if (mem_own) begin
            rep_v = 1'b1;
            if (rtype == RQ_EXCL && (cur_vec & req_bit) != '0) rep_k = RP_GRANT;
            if (others != '0) begin
              ord_v   = 1'b1;
              ord_k   = OD_INVAL;
              ord_msk = others;
            end
          end else begin
            ord_v   = 1'b1;
            ord_k   = OD_FWD_RDEX;
            ord_msk = others;
          end
        end
        RQ_EXND: begin
          wr      = 1'b1;
          nxt_own = rid;
          nxt_vec = '0;
          rep_v   = 1'b1;
          rep_k   = RP_GRANT;
          if (exnd_msk != '0) begin
            ord_v   = 1'b1;
            ord_k   = OD_INVAL;
            ord_msk = exnd_msk;
          end
        end
        RQ_WBACK: begin
          if (cur_own == rid) begin
            wr      = 1'b1;
            nxt_own = MEM_OWNER;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dirc_out_stage.sv
module dirc_out_stage
  import dirc_pkg::*;
#(
  parameter int NODES = 8,
  parameter int PROCS_PER_NODE = 4,
  parameter int ID_W = 6,
  parameter int LINE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_rep_v,
  input  logic              in_rep_k,
  input  logic              in_ord_v,
  input  logic [1:0]        in_ord_k,
  input  logic [ID_W-1:0]   in_ord_own,
  input  logic [NODES-1:0]  in_ord_msk,
  input  logic [ID_W-1:0]   in_id,
  input  logic [LINE_W-1:0] in_addr,
  output logic              rep_valid,
  output logic              rep_kind,
  output logic [ID_W-1:0]   rep_dest,
  output logic [LINE_W-1:0] rep_addr,
  output logic              ord_valid,
  output logic [1:0]        ord_kind,
  output logic [ID_W-1:0]   ord_owner,
  output logic [ID_W-1:0]   ord_req,
  output logic [NODES-1:0]  ord_mask,
  output logic [LINE_W-1:0] ord_addr
);
  localparam int NODE_W = $clog2(NODES);
  localparam int PSH    = $clog2(PROCS_PER_NODE);
  localparam logic [ID_W-1:0] MEM_OWNER = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      rep_valid <= 1'b0;
      rep_kind  <= 1'b0;
      rep_dest  <= '0;
      rep_addr  <= '0;
      ord_valid <= 1'b0;
      ord_kind  <= 2'd0;
      ord_owner <= '0;
      ord_req   <= '0;
      ord_mask  <= '0;
      ord_addr  <= '0;
    end else begin
      rep_valid <= in_rep_v;
      rep_kind  <= in_rep_k;
      rep_dest  <= in_id;
      rep_addr  <= in_addr;
      ord_valid <= in_ord_v;
      ord_kind  <= in_ord_k;
      ord_owner <= in_ord_own;
      ord_req   <= in_id;
      ord_mask  <= in_ord_msk;
      ord_addr  <= in_addr;
    end
  end

  AST_INVAL_MASK_OK: assert property (@(posedge clk) disable iff (rst)
    (ord_valid && ord_kind == OD_INVAL) |->
      (ord_mask != '0 && !ord_mask[ord_req[PSH +: NODE_W]])); // R9

  AST_FWD_NO_REPLY: assert property (@(posedge clk) disable iff (rst)
    (ord_valid && ord_kind != OD_INVAL) |->
      (!rep_valid && ord_owner != MEM_OWNER)); // R4

endmodule

// File: rtl/dirc_home.sv
module dirc_home
  import dirc_pkg::*;
#(
  parameter int NODES = 8,
  parameter int PROCS_PER_NODE = 4,
  parameter int ID_W = 6,
  parameter int LINE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_type,
  input  logic [LINE_W-1:0] req_addr,
  input  logic [ID_W-1:0]   req_id,
  output logic              rep_valid,
  output logic              rep_kind,
  output logic [ID_W-1:0]   rep_dest,
  output logic [LINE_W-1:0] rep_addr,
  output logic              ord_valid,
  output logic [1:0]        ord_kind,
  output logic [ID_W-1:0]   ord_owner,
  output logic [ID_W-1:0]   ord_req,
  output logic [NODES-1:0]  ord_mask,
  output logic [LINE_W-1:0] ord_addr
);
  localparam int ENTRY_W = ID_W + NODES;
  localparam int LINES   = 1 << LINE_W;
  localparam logic [ID_W-1:0] MEM_OWNER = '1;

  // stage 1 request registers
  logic              s1_v;
  logic [2:0]        s1_type;
  logic [LINE_W-1:0] s1_addr;
  logic [ID_W-1:0]   s1_id;

  // entry-valid flags: a cleared flag reads as memory-owned, empty vector
  logic [LINES-1:0]  line_vld;
  logic              vld_q;

  // last write, kept one cycle for the bypass
  logic              wr_v_q;
  logic [LINE_W-1:0] wr_addr_q;
  logic [ENTRY_W-1:0] wr_ent_q;

  logic [ENTRY_W-1:0] ram_rd;
  logic [ENTRY_W-1:0] cur_ent;

  logic              pol_wr;
  logic [ID_W-1:0]   pol_own;
  logic [NODES-1:0]  pol_vec;
  logic              pol_rep_v;
  logic              pol_rep_k;
  logic              pol_ord_v;
  logic [1:0]        pol_ord_k;
  logic [ID_W-1:0]   pol_ord_own;
  logic [NODES-1:0]  pol_ord_msk;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v     <= 1'b0;
      s1_type  <= '0;
      s1_addr  <= '0;
      s1_id    <= '0;
      vld_q    <= 1'b0;
      line_vld <= '0;
      wr_v_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_ent_q <= '0;
    end else begin
      s1_v     <= req_valid;
      s1_type  <= req_type;
      s1_addr  <= req_addr;
      s1_id    <= req_id;
      vld_q    <= line_vld[req_addr];
      if (pol_wr) line_vld[s1_addr] <= 1'b1;
      wr_v_q   <= pol_wr;
      wr_addr_q <= s1_addr;
      wr_ent_q <= {pol_own, pol_vec};
    end
  end

  always_comb begin
    if (wr_v_q && wr_addr_q == s1_addr) cur_ent = wr_ent_q;
    else if (vld_q)                     cur_ent = ram_rd;
    else                                cur_ent = {MEM_OWNER, {NODES{1'b0}}};
  end

  dirc_dir_ram #(
    .ENTRY_W(ENTRY_W),
    .LINE_W (LINE_W)
  ) ram_i (
    .clk  (clk),
    .rst  (rst),
    .we   (pol_wr),
    .waddr(s1_addr),
    .wdata({pol_own, pol_vec}),
    .re   (req_valid),
    .raddr(req_addr),
    .rdata(ram_rd)
  );

  dirc_policy #(
    .NODES(NODES),
    .PROCS_PER_NODE(PROCS_PER_NODE),
    .ID_W(ID_W)
  ) pol_i (
    .valid  (s1_v),
    .rtype  (s1_type),
    .rid    (s1_id),
    .cur_own(cur_ent[ENTRY_W-1 -: ID_W]),
    .cur_vec(cur_ent[NODES-1:0]),
    .wr     (pol_wr),
    .nxt_own(pol_own),
    .nxt_vec(pol_vec),
    .rep_v  (pol_rep_v),
    .rep_k  (pol_rep_k),
    .ord_v  (pol_ord_v),
    .ord_k  (pol_ord_k),
    .ord_own(pol_ord_own),
    .ord_msk(pol_ord_msk)
  );

  dirc_out_stage #(
    .NODES(NODES),
    .PROCS_PER_NODE(PROCS_PER_NODE),
    .ID_W(ID_W),
    .LINE_W(LINE_W)
  ) out_i (
    .clk       (clk),
    .rst       (rst),
    .in_rep_v  (pol_rep_v),
    .in_rep_k  (pol_rep_k),
    .in_ord_v  (pol_ord_v),
    .in_ord_k  (pol_ord_k),
    .in_ord_own(pol_ord_own),
    .in_ord_msk(pol_ord_msk),
    .in_id     (s1_id),
    .in_addr   (s1_addr),
    .rep_valid (rep_valid),
    .rep_kind  (rep_kind),
    .rep_dest  (rep_dest),
    .rep_addr  (rep_addr),
    .ord_valid (ord_valid),
    .ord_kind  (ord_kind),
    .ord_owner (ord_owner),
    .ord_req   (ord_req),
    .ord_mask  (ord_mask),
    .ord_addr  (ord_addr)
  );

  AST_OUT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    (rep_valid || ord_valid) |-> $past(s1_v)); // R2

  AST_WB_SILENT: assert property (@(posedge clk) disable iff (rst)
    (s1_v && s1_type == RQ_WBACK) |=> (!rep_valid && !ord_valid)); // R8

  AST_EXND_GRANT: assert property (@(posedge clk) disable iff (rst)
    (s1_v && s1_type == RQ_EXND) |=> (rep_valid && rep_kind == RP_GRANT)); // R7

  AST_UNKNOWN_SILENT: assert property (@(posedge clk) disable iff (rst)
    (s1_v && s1_type > 3'd4) |=> (!rep_valid && !ord_valid)); // R10

endmodule

// File: tb/dirc_home_tb_top.sv
module dirc_home_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  // {req[37:34], type[33:31], addr[30:25], id[24:19], rep_v[18], rep_k[17],
  //  ord_v[16], ord_k[15:14], ord_owner[13:8], ord_mask[7:0]}
  localparam logic [37:0] VEC [NV] = '{
    {4'd3,  3'd0, 6'd5,  6'd1,  1'b1, 1'b0, 1'b0, 2'd0, 6'h00, 8'h00}, // R3
    {4'd3,  3'd0, 6'd5,  6'd9,  1'b1, 1'b0, 1'b0, 2'd0, 6'h00, 8'h00}, // R3
    {4'd5,  3'd1, 6'd5,  6'd13, 1'b1, 1'b0, 1'b1, 2'd2, 6'h3F, 8'h05}, // R5
    {4'd4,  3'd0, 6'd5,  6'd20, 1'b0, 1'b0, 1'b1, 2'd0, 6'd13, 8'h00}, // R4
    {4'd4,  3'd0, 6'd5,  6'd4,  1'b0, 1'b0, 1'b1, 2'd0, 6'd13, 8'h00}, // R4
    {4'd9,  3'd1, 6'd5,  6'd28, 1'b0, 1'b0, 1'b1, 2'd1, 6'd13, 8'h22}, // R9 R5
    {4'd8,  3'd4, 6'd5,  6'd13, 1'b0, 1'b0, 1'b0, 2'd0, 6'h00, 8'h00}, // R8
    {4'd8,  3'd0, 6'd5,  6'd0,  1'b0, 1'b0, 1'b1, 2'd0, 6'd28, 8'h00}, // R8
    {4'd8,  3'd4, 6'd5,  6'd28, 1'b0, 1'b0, 1'b0, 2'd0, 6'h00, 8'h00}, // R8
    {4'd3,  3'd0, 6'd5,  6'd8,  1'b1, 1'b0, 1'b0, 2'd0, 6'h00, 8'h00}, // R3
    {4'd6,  3'd2, 6'd5,  6'd9,  1'b1, 1'b1, 1'b1, 2'd2, 6'h3F, 8'h01}, // R6
    {4'd6,  3'd2, 6'd7,  6'd6,  1'b1, 1'b0, 1'b0, 2'd0, 6'h00, 8'h00}, // R6
    {4'd7,  3'd3, 6'd7,  6'd30, 1'b1, 1'b1, 1'b1, 2'd2, 6'd6,  8'h02}, // R7
    {4'd7,  3'd3, 6'd9,  6'd3,  1'b1, 1'b1, 1'b0, 2'd0, 6'h00, 8'h00}, // R7
    {4'd10, 3'd5, 6'd9,  6'd3,  1'b0, 1'b0, 1'b0, 2'd0, 6'h00, 8'h00}, // R10
    {4'd10, 3'd0, 6'd9,  6'd17, 1'b0, 1'b0, 1'b1, 2'd0, 6'd3,  8'h00}, // R10
    {4'd6,  3'd2, 6'd5,  6'd24, 1'b0, 1'b0, 1'b1, 2'd1, 6'd9,  8'h00}, // R6
    {4'd3,  3'd0, 6'd63, 6'd31, 1'b1, 1'b0, 1'b0, 2'd0, 6'h00, 8'h00}  // R3
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [2:0] req_type = '0;
  logic [5:0] req_addr = '0;
  logic [5:0] req_id = '0;
  logic       rep_valid, rep_kind;
  logic [5:0] rep_dest, rep_addr;
  logic       ord_valid;
  logic [1:0] ord_kind;
  logic [5:0] ord_owner, ord_req, ord_addr;
  logic [7:0] ord_mask;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dirc_home dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_type(req_type),
    .req_addr(req_addr), .req_id(req_id),
    .rep_valid(rep_valid), .rep_kind(rep_kind), .rep_dest(rep_dest),
    .rep_addr(rep_addr), .ord_valid(ord_valid), .ord_kind(ord_kind),
    .ord_owner(ord_owner), .ord_req(ord_req), .ord_mask(ord_mask),
    .ord_addr(ord_addr)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic drive(input logic [2:0] t, input logic [5:0] a, input logic [5:0] id);
    req_valid = 1'b1;
    req_type  = t;
    req_addr  = a;
    req_id    = id;
  endtask

  task automatic check_out(input string req, input logic rv, input logic rk,
                           input logic [5:0] rdst, input logic [5:0] a,
                           input logic ov, input logic [1:0] ok,
                           input logic [5:0] own, input logic [7:0] msk);
    chk(req, "rep_valid", 32'(rep_valid), 32'(rv));
    if (rv) begin
      chk(req, "rep_kind", 32'(rep_kind), 32'(rk));
      chk(req, "rep_dest", 32'(rep_dest), 32'(rdst));
      chk(req, "rep_addr", 32'(rep_addr), 32'(a));
    end
    chk(req, "ord_valid", 32'(ord_valid), 32'(ov));
    if (ov) begin
      chk(req, "ord_kind", 32'(ord_kind), 32'(ok));
      chk(req, "ord_owner", 32'(ord_owner), 32'(own));
      chk(req, "ord_mask", 32'(ord_mask), 32'(msk));
      chk(req, "ord_req", 32'(ord_req), 32'(rdst));
      chk(req, "ord_addr", 32'(ord_addr), 32'(a));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1: idle outputs after reset
    chk("R1", "rep_valid idle", 32'(rep_valid), 32'd0);
    chk("R1", "ord_valid idle", 32'(ord_valid), 32'd0);

    // table walk, one request at a time
    for (int i = 0; i < NV; i++) begin
      logic [37:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d#%0d", v[37:34], i);
      @(negedge clk);
      drive(v[33:31], v[30:25], v[24:19]);
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      check_out(tag, v[18], v[17], v[24:19], v[30:25], v[16], v[15:14], v[13:8], v[7:0]);
    end

    // R2: back-to-back to one fresh line, bypass must carry each update
    @(negedge clk);
    drive(3'd0, 6'd40, 6'd0);
    @(negedge clk);
    drive(3'd1, 6'd40, 6'd5);
    @(negedge clk);
    drive(3'd0, 6'd40, 6'd12);
    check_out("R2 first", 1'b1, 1'b0, 6'd0, 6'd40, 1'b0, 2'd0, 6'd0, 8'h00);
    @(negedge clk);
    req_valid = 1'b0;
    check_out("R2 second", 1'b1, 1'b0, 6'd5, 6'd40, 1'b1, 2'd2, 6'h3F, 8'h01);
    @(negedge clk);
    check_out("R2 third", 1'b0, 1'b0, 6'd12, 6'd40, 1'b1, 2'd0, 6'd5, 8'h00);
    @(negedge clk);
    chk("R2", "quiet after burst", 32'(rep_valid | ord_valid), 32'd0);

    // R1: reset during operation returns line 5 and line 40 to memory
    do_reset();
    @(negedge clk);
    chk("R1", "rep_valid after mid reset", 32'(rep_valid), 32'd0);
    drive(3'd0, 6'd5, 6'd2);
    @(negedge clk);
    drive(3'd1, 6'd40, 6'd16);
    @(negedge clk);
    req_valid = 1'b0;
    check_out("R1 line5", 1'b1, 1'b0, 6'd2, 6'd5, 1'b0, 2'd0, 6'd0, 8'h00);
    @(negedge clk);
    check_out("R1 line40", 1'b1, 1'b0, 6'd16, 6'd40, 1'b0, 2'd0, 6'd0, 8'h00);

    // R10: type 7 ignored, line 40 still owned by id 16
    @(negedge clk);
    drive(3'd7, 6'd40, 6'd1);
    @(negedge clk);
    drive(3'd0, 6'd40, 6'd1);
    @(negedge clk);
    req_valid = 1'b0;
    check_out("R10 type7", 1'b0, 1'b0, 6'd1, 6'd40, 1'b0, 2'd0, 6'd0, 8'h00);
    @(negedge clk);
    check_out("R10 after", 1'b0, 1'b0, 6'd1, 6'd40, 1'b1, 2'd0, 6'd16, 8'h00);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule